// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This block makes the processor-side decision on whether an interrupt is taken, and in which order. Three kinds of event compete for it. The first is a non-maskable event. The second is a software interrupt command that carries a vector and, optionally, a new priority level. The third is the maskable request that an upstream priority arbiter presents together with its level and vector. The block holds the enable bit and the current-level field of the status word, and keeps one saved copy of both.

Each cycle it picks at most one event. On the next clock edge it reports the accepted event (kind and vector) for exactly one cycle, saves the old status, clears the enable bit and moves the level as the event demands. When the maskable request is the one taken, it acknowledges the arbiter. A plain load input models an instruction that writes the status word. A restore input models the return from an interrupt by reloading the saved copy.

The software command is a valid/ready stream. A command is consumed on a clock edge where `sw_valid` and `sw_ready` are both high. `sw_ready` is low only while the non-maskable input is high. A stalled command must hold its vector and level fields stable until it is consumed. The maskable request uses the arbiter's request/acknowledge pair: the arbiter holds `hw_req`, `hw_lvl` and `hw_vec` until `hw_ack`, and it may replace them with a higher-priority request at any time before that.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the enable bit is 0 and the current level is 0. `take_valid` and `hw_ack` stay 0 until an event is accepted.
- R2: The maskable request is taken only when the enable bit is 1 and `hw_lvl` is strictly greater than the current level. In that case, one cycle later, `take_valid`=1, `take_src`=3 and `take_vec`=`hw_vec`.
- R3: A maskable request whose level is equal to or below the current level is not taken. It stays pending with no acknowledge.
- R4: The non-maskable input is taken whatever the enable bit and level are. It reports `take_src`=1 with the fixed vector `NMI_VEC` (default 2), and it leaves the current level unchanged.
- R5: Precedence is non-maskable, then software, then maskable. While `nmi` is high, `sw_ready` is 0. Any losing event stays pending.
- R6: A software command is taken whatever the enable bit and level are. It reports `take_src`=2 with `take_vec`=`sw_vec` (0 to 31). When `sw_set_lvl`=1, the current level becomes `sw_lvl`. When `sw_set_lvl`=0, the current level is kept.
- R7: On any acceptance the old enable bit and level are saved and the enable bit is cleared. A maskable acceptance sets the current level to the accepted `hw_lvl`.
- R8: `st_restore` reloads the enable bit and the level from the saved copy one cycle later.
- R9: `st_load` writes `st_load_ie` and `st_load_lvl` into the status one cycle later, and it wins over a simultaneous restore. Both load and restore are ignored in a cycle in which an event is accepted.
- R10: `hw_ack` is a single-cycle pulse that coincides with a maskable acceptance. It is never raised for a non-maskable or software acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 1 | Maskable request from the arbiter |
| hw_lvl | input | 3 | Level of the maskable request |
| hw_vec | input | 5 | Vector of the maskable request |
| hw_ack | output | 1 | Acceptance pulse back to the arbiter |
| nmi | input | 1 | Non-maskable event, one event per high cycle |
| sw_valid | input | 1 | Software interrupt command present |
| sw_ready | output | 1 | Software command can be consumed this cycle |
| sw_vec | input | 5 | Vector carried by the software command |
| sw_set_lvl | input | 1 | Software command also loads the level field |
| sw_lvl | input | 3 | Level carried by the software command |
| st_load | input | 1 | Write the status word |
| st_load_ie | input | 1 | Enable value to write |
| st_load_lvl | input | 3 | Level value to write |
| st_restore | input | 1 | Reload the status from the saved copy |
| take_valid | output | 1 | An event was accepted (one cycle) |
| take_src | output | 2 | Accepted kind: 0 none, 1 non-maskable, 2 software, 3 maskable |
| take_vec | output | 5 | Accepted vector |
| ie | output | 1 | Current enable bit |
| cur_lvl | output | 3 | Current level field |

## Verification
The hardest case to reach is a single cycle in which all three kinds of event arrive together with a status restore. It exposes the precedence chain, the `sw_ready` back-pressure and the rule that restore is dropped on an acceptance. The stimulus first writes the status word so that the maskable request would qualify. It then raises all three events at once and keeps the losers asserted. This lets them win on following cycles, with a restore pulse placed on the cycle where the software command is taken. The equal-level case and the level kept across a non-maskable event are reached by loading the status directly before each request.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_HW   = 2'd3
  } src_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_accept_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int VEC_W   = 5,
  parameter int NMI_VEC = 2
) (
  input  logic             hw_req,
  input  logic [LVL_W-1:0] hw_lvl,
  input  logic [VEC_W-1:0] hw_vec,
  input  logic             nmi,
  input  logic             sw_valid,
  input  logic [VEC_W-1:0] sw_vec,
  input  logic             sw_set_lvl,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             ie,
  input  logic [LVL_W-1:0] cur_lvl,
  output src_e             src,
  output logic [VEC_W-1:0] pick_vec,
  output logic [LVL_W-1:0] next_lvl,
  output logic             sw_ready
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

  logic hw_ok;

  // Software commands yield only to the non-maskable event.
  assign sw_ready = !nmi;
  // Threshold mask: strictly above the current level, and enabled.
  assign hw_ok    = hw_req && ie && (hw_lvl > cur_lvl);

  always_comb begin
    src      = SRC_NONE;
    pick_vec = '0;
    next_lvl = cur_lvl;
    if (nmi) begin
      src      = SRC_NMI;
      pick_vec = NMI_V;
    end else if (sw_valid) begin
      src      = SRC_SW;
      pick_vec = sw_vec;
      if (sw_set_lvl) next_lvl = sw_lvl;
    end else if (hw_ok) begin
      src      = SRC_HW;
      pick_vec = hw_vec;
      next_lvl = hw_lvl;
    end
  end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [LVL_W-1:0] take_lvl,
  input  logic             ld,
  input  logic             ld_ie,
  input  logic [LVL_W-1:0] ld_lvl,
  input  logic             restore,
  output logic             ie,
  output logic [LVL_W-1:0] lvl
);
  logic             sv_ie;
  logic [LVL_W-1:0] sv_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie     <= 1'b0;
      lvl    <= '0;
      sv_ie  <= 1'b0;
      sv_lvl <= '0;
    end else if (take) begin
      sv_ie  <= ie;
      sv_lvl <= lvl;
      ie     <= 1'b0;
      lvl    <= take_lvl;
    end else if (ld) begin
      ie     <= ld_ie;
      lvl    <= ld_lvl;
    end else if (restore) begin
      ie     <= sv_ie;
      lvl    <= sv_lvl;
    end
  end

  AST_TAKE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ie) else $error("take left ie set"); // R7
  AST_RESTORE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !take && !ld) |=> (ie == $past(sv_ie) && lvl == $past(sv_lvl)))
    else $error("restore mismatch"); // R8
  AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !take) |=> (ie == $past(ld_ie) && lvl == $past(ld_lvl)))
    else $error("load mismatch"); // R9
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int VEC_W   = 5,
  parameter int NMI_VEC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_req,
  input  logic [LVL_W-1:0] hw_lvl,
  input  logic [VEC_W-1:0] hw_vec,
  output logic             hw_ack,
  input  logic             nmi,
  input  logic             sw_valid,
  output logic             sw_ready,
  input  logic [VEC_W-1:0] sw_vec,
  input  logic             sw_set_lvl,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             st_load,
  input  logic             st_load_ie,
  input  logic [LVL_W-1:0] st_load_lvl,
  input  logic             st_restore,
  output logic             take_valid,
  output logic [1:0]       take_src,
  output logic [VEC_W-1:0] take_vec,
  output logic             ie,
  output logic [LVL_W-1:0] cur_lvl
);
  src_e             pick_src;
  logic [VEC_W-1:0] pick_vec;
  logic [LVL_W-1:0] next_lvl;
  logic             take;
  logic             run_q;

  irq_pick #(.LVL_W(LVL_W), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_pick (
    .hw_req(hw_req), .hw_lvl(hw_lvl), .hw_vec(hw_vec), .nmi(nmi),
    .sw_valid(sw_valid), .sw_vec(sw_vec), .sw_set_lvl(sw_set_lvl),
    .sw_lvl(sw_lvl), .ie(ie), .cur_lvl(cur_lvl), .src(pick_src),
    .pick_vec(pick_vec), .next_lvl(next_lvl), .sw_ready(sw_ready)
  );

  assign take = (pick_src != SRC_NONE);

  irq_status #(.LVL_W(LVL_W)) u_status (
    .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(next_lvl),
    .ld(st_load), .ld_ie(st_load_ie), .ld_lvl(st_load_lvl),
    .restore(st_restore), .ie(ie), .lvl(cur_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_valid <= 1'b0;
      take_src   <= SRC_NONE;
      take_vec   <= '0;
      hw_ack     <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      take_valid <= take;
      take_src   <= pick_src;
      take_vec   <= pick_vec;
      hw_ack     <= (pick_src == SRC_HW);
      run_q      <= 1'b1;
    end
  end

  AST_HW_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && take_valid && take_src == SRC_HW) |->
      ($past(ie) && $past(hw_lvl) > $past(cur_lvl))) else $error("unqualified hw take"); // R2
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(nmi)) |-> (take_valid && take_src == SRC_NMI)) else $error("nmi lost"); // R4
  AST_NMI_BLOCKS_SW: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> !sw_ready) else $error("sw ready during nmi"); // R5
  AST_SW_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(sw_valid && sw_ready)) |-> (take_src == SRC_SW)) else $error("sw lost"); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |=> !hw_ack) else $error("ack longer than a cycle"); // R10
endmodule

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_req = 0, nmi = 0, sw_valid = 0, sw_set_lvl = 0;
  logic st_load = 0, st_load_ie = 0, st_restore = 0;
  logic [2:0] hw_lvl = 0, sw_lvl = 0, st_load_lvl = 0;
  logic [4:0] hw_vec = 0, sw_vec = 0;
  logic hw_ack, sw_ready, take_valid, ie;
  logic [1:0] take_src;
  logic [4:0] take_vec;
  logic [2:0] cur_lvl;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_accept_unit i_irq_accept_unit (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_lvl(hw_lvl), .hw_vec(hw_vec),
    .hw_ack(hw_ack), .nmi(nmi), .sw_valid(sw_valid), .sw_ready(sw_ready),
    .sw_vec(sw_vec), .sw_set_lvl(sw_set_lvl), .sw_lvl(sw_lvl), .st_load(st_load),
    .st_load_ie(st_load_ie), .st_load_lvl(st_load_lvl), .st_restore(st_restore),
    .take_valid(take_valid), .take_src(take_src), .take_vec(take_vec),
    .ie(ie), .cur_lvl(cur_lvl)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Outputs as one vector: {take_valid, take_src, hw_ack, ie, cur_lvl}
  task automatic check_out(string req, logic tv, logic [1:0] ts, logic ak, logic e, logic [2:0] l);
    check(req, {take_valid, take_src, hw_ack, ie, cur_lvl}, {tv, ts, ak, e, l});
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(logic e, logic [2:0] l);
    st_load = 1; st_load_ie = e; st_load_lvl = l;
    tick();
    st_load = 0;
    check_out("R9 load", 0, 0, 0, e, l);
  endtask

  task automatic t_reset();
    check_out("R1 reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_maskable();
    hw_req = 1; hw_lvl = 5; hw_vec = 9;
    tick();
    check_out("R2 disabled", 0, 0, 0, 0, 0);
    hw_req = 0;
    load(1, 3);
    hw_req = 1; hw_lvl = 3;
    tick();
    check_out("R3 equal level", 0, 0, 0, 1, 3);
    hw_lvl = 4;
    tick();
    check_out("R2 R7 taken", 1, 3, 1, 0, 4);
    check("R2 vector", {3'b0, take_vec}, 8'd9);
    tick();
    check_out("R10 single ack", 0, 0, 0, 0, 4);
    hw_req = 0;
    st_restore = 1;
    tick();
    st_restore = 0;
    check_out("R8 restore", 0, 0, 0, 1, 3);
  endtask

  task automatic t_nmi();
    load(0, 7);
    nmi = 1;
    tick();
    nmi = 0;
    check_out("R4 nmi", 1, 1, 0, 0, 7);
    check("R4 vector", {3'b0, take_vec}, 8'd2);
    load(1, 6);
    nmi = 1;
    tick();
    nmi = 0;
    check_out("R4 R7 nmi keeps level", 1, 1, 0, 0, 6);
    st_restore = 1;
    tick();
    st_restore = 0;
    check_out("R8 restore after nmi", 0, 0, 0, 1, 6);
  endtask

  task automatic t_sw();
    load(0, 5);
    sw_valid = 1; sw_vec = 17; sw_set_lvl = 0; sw_lvl = 1;
    tick();
    check_out("R6 sw no level", 1, 2, 0, 0, 5);
    check("R6 vector", {3'b0, take_vec}, 8'd17);
    sw_vec = 31; sw_set_lvl = 1; sw_lvl = 2;
    tick();
    sw_valid = 0;
    check_out("R6 sw with level", 1, 2, 0, 0, 2);
    check("R6 vector 31", {3'b0, take_vec}, 8'd31);
  endtask

  task automatic t_prio();
    load(1, 0);
    nmi = 1; sw_valid = 1; sw_vec = 4; sw_set_lvl = 0;
    hw_req = 1; hw_lvl = 6; hw_vec = 12;
    #1;
    check("R5 sw_ready low", {7'b0, sw_ready}, 8'd0);
    tick();
    nmi = 0;
    check_out("R5 nmi wins", 1, 1, 0, 0, 0);
    st_restore = 1;
    tick();
    st_restore = 0;
    check_out("R5 R9 sw next, restore ignored", 1, 2, 0, 0, 0);
    check("R5 sw vector", {3'b0, take_vec}, 8'd4);
    sw_valid = 0;
    load(1, 0);
    tick();
    hw_req = 0;
    check_out("R5 R10 hw last", 1, 3, 1, 0, 6);
    check("R5 hw vector", {3'b0, take_vec}, 8'd12);
  endtask

  task automatic t_load_restore();
    st_load = 1; st_load_ie = 1; st_load_lvl = 1; st_restore = 1;
    tick();
    st_load = 0; st_restore = 0;
    check_out("R9 load beats restore", 0, 0, 0, 1, 1);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_maskable();
    t_nmi();
    t_sw();
    t_prio();
    t_load_restore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule